// File: doc/BRIEF.md
# Binary64 Round and Pack Unit

This unit is the last stage of a floating-point datapath. It accepts a sign, a signed unbiased exponent and an extended mantissa. The mantissa holds the hidden bit, the fraction and three extra low bits: guard, round and sticky. The unit rounds the value under one of four modes and packs it into a binary64 word. It also raises the inexact, underflow and overflow flags.

Values below the smallest normal exponent are either denormalised with a sticky right shift or, when flush is on, replaced by a signed zero or the smallest denormal. Tininess is judged after rounding at the boundary exponent. Overflowing values saturate to infinity or to the largest finite number, chosen by both rounding mode and sign.

The arithmetic that produces the operand sits upstream. The operand is never zero and always has its hidden bit set. The result is registered and appears one cycle after the input is accepted.

Top module: `fp_round_pack`

## Requirements
- R1: `out_valid` rises one clock after an input is accepted with `in_valid` high. When `in_valid` is low, `out_valid` is low on the next cycle and the result and flags hold their values.
- R2: The rounding mode encoding is 0 = nearest-even, 1 = toward zero, 2 = toward +infinity and 3 = toward -infinity. The discarded bits are rounded in the selected mode onto the grid of the output format.
- R3: `out_inexact` is set whenever any discarded bit of the value is nonzero, and whenever the result overflows or is flushed.
- R4: When the exponent is below the minimum normal exponent and flush is off, the mantissa is shifted right until it reaches that exponent, and every bit shifted out is folded into the sticky bit. A result with the hidden bit clear is packed with exponent field 0.
- R5: When the exponent is one below the minimum and rounding at the input's own precision carries out of the top bit, the value is not tiny. The result is the smallest normal number, inexact is set and underflow is not set.
- R6: A tiny value that loses bits raises underflow, even if rounding lifts it to the smallest normal.
- R7: An exactly representable denormal raises underflow only when `uf_trap_en` is 1.
- R8: When the rounded exponent exceeds the maximum, overflow and inexact are set. The result is infinity for nearest-even, for toward +infinity with a positive sign and for toward -infinity with a negative sign. Otherwise it is the largest finite value with the input sign.
- R9: With `flush_en` set and the exponent below the minimum, underflow and inexact are set. The result is the smallest denormal for toward +infinity with a positive sign and for toward -infinity with a negative sign. Otherwise it is a zero. The input sign is kept in both cases.
- R10: A normal result is packed with the exponent plus the bias (1023 by default) and the hidden bit removed. A rounding carry out of the top bit shifts the mantissa right and increments the exponent.
- R11: During reset, `out_valid`, the result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand present |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | XE_W (13) | Signed unbiased exponent |
| in_mant | input | FRAC_W+4 (56) | Hidden bit, fraction, guard, round, sticky |
| rnd_mode | input | 2 | Rounding mode (see R2) |
| flush_en | input | 1 | Flush tiny values instead of denormalising |
| uf_trap_en | input | 1 | Underflow enabled for exact denormals |
| out_valid | output | 1 | Result present |
| out_result | output | 1+EXP_W+FRAC_W (64) | Packed result |
| out_inexact | output | 1 | Inexact flag |
| out_underflow | output | 1 | Underflow flag |
| out_overflow | output | 1 | Overflow flag |

## Verification
The embedded assertions check on every cycle the handshake timing and the hold of the result. They also check that overflow always carries inexact and that the overflow result has an infinity or largest-finite encoding. They check that underflow and overflow never appear together, and that a flushed input always raises underflow and inexact. Exact rounding values, the tininess decision at the boundary exponent and the conditional underflow for exact denormals can be shown only by the bench. It sweeps a reduced format exhaustively against an exact rational rounding model, and adds directed binary64 cases for the bias and for shift clamping.

// File: rtl/fp_round_pack.sv
module fp_round_pack #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int XE_W   = 13
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_sign,
  input  logic [XE_W-1:0]           in_exp,
  input  logic [FRAC_W+3:0]         in_mant,
  input  logic [1:0]                rnd_mode,
  input  logic                      flush_en,
  input  logic                      uf_trap_en,
  output logic                      out_valid,
  output logic [EXP_W+FRAC_W:0]     out_result,
  output logic                      out_inexact,
  output logic                      out_underflow,
  output logic                      out_overflow
);
  localparam int MW    = FRAC_W + 4;
  localparam int RW    = 1 + EXP_W + FRAC_W;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int EMIN  = 1 - BIAS;
  localparam int EMAX  = BIAS;
  localparam int SHMAX = FRAC_W + 6;
  localparam logic [1:0] RM_NEAR = 2'd0;
  localparam logic [1:0] RM_UP   = 2'd2;
  localparam logic [1:0] RM_DOWN = 2'd3;
  localparam logic [EXP_W-1:0] EXP_ONES = '1;

  function automatic logic [MW:0] apply_round(input logic [MW-1:0] m, input logic s,
                                              input logic [1:0] md);
    logic [MW:0] inc;
    inc = '0;
    if (|m[2:0]) begin
      case (md)
        2'd0:    inc = (MW+1)'(m[3] ? 4 : 3);
        2'd2:    inc = (MW+1)'(s ? 0 : 8);
        2'd3:    inc = (MW+1)'(s ? 8 : 0);
        default: inc = '0;
      endcase
    end
    return {1'b0, m} + inc;
  endfunction

  int              e_in;
  logic            tiny, at_edge, edge_carry, flush_hit;
  logic [MW:0]     edge_rnd;
  logic [MW-1:0]   m_sh, lost_mask, m_st, m0;
  logic [MW:0]     m1;
  logic [MW-1:0]   m2;
  int              shv, x0, x1;
  logic            pre_inexact, grs_nz, ovf_hit, pick_ext;
  logic [RW-1:0]   res_c;
  logic            ix_c, uf_c, ov_c;

  assign e_in       = int'($signed(in_exp));
  assign tiny       = e_in < EMIN;
  assign at_edge    = e_in == EMIN - 1;
  assign flush_hit  = tiny && flush_en;
  assign edge_rnd   = apply_round(in_mant, in_sign, rnd_mode);
  assign edge_carry = at_edge && edge_rnd[MW];
  assign pick_ext   = (rnd_mode == RM_UP && !in_sign) || (rnd_mode == RM_DOWN && in_sign);

  always_comb begin
    shv = EMIN - e_in;
    if (!tiny) shv = 0;
    else if (shv > SHMAX) shv = SHMAX;
    m_sh      = in_mant >> shv;
    lost_mask = ~({MW{1'b1}} << shv);
    m_st      = {m_sh[MW-1:1], m_sh[0] | (|(in_mant & lost_mask))};
  end

  always_comb begin
    pre_inexact = 1'b0;
    if (edge_carry) begin
      m0 = {1'b1, {(MW-1){1'b0}}};
      x0 = EMIN;
      pre_inexact = 1'b1;
    end else if (tiny) begin
      m0 = m_st;
      x0 = EMIN;
    end else begin
      m0 = in_mant;
      x0 = e_in;
    end
    grs_nz = |m0[2:0];
    m1 = apply_round(m0, in_sign, rnd_mode);
    if (m1[MW]) begin
      m2 = m1[MW:1];
      x1 = x0 + 1;
    end else begin
      m2 = m1[MW-1:0];
      x1 = x0;
    end
    ovf_hit = x1 > EMAX;
  end

  always_comb begin
    ix_c = pre_inexact | grs_nz;
    uf_c = grs_nz && !m0[MW-1];
    ov_c = 1'b0;
    if (flush_hit) begin
      ix_c  = 1'b1;
      uf_c  = 1'b1;
      res_c = {in_sign, {EXP_W{1'b0}}, (FRAC_W)'(pick_ext ? 1 : 0)};
    end else if (ovf_hit) begin
      ix_c = 1'b1;
      ov_c = 1'b1;
      uf_c = 1'b0;
      if (rnd_mode == RM_NEAR || pick_ext)
        res_c = {in_sign, EXP_ONES, {FRAC_W{1'b0}}};
      else
        res_c = {in_sign, EXP_ONES - 1'b1, {FRAC_W{1'b1}}};
    end else if (!m2[MW-1]) begin
      uf_c  = uf_c | uf_trap_en;
      res_c = {in_sign, {EXP_W{1'b0}}, m2[MW-2:3]};
    end else begin
      res_c = {in_sign, EXP_W'(x1 + BIAS), m2[MW-2:3]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_result    <= '0;
      out_inexact   <= 1'b0;
      out_underflow <= 1'b0;
      out_overflow  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result    <= res_c;
        out_inexact   <= ix_c;
        out_underflow <= uf_c;
        out_overflow  <= ov_c;
      end
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_result) && $stable(out_inexact));
  assert_ovf_inexact_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_overflow |-> out_inexact);
  assert_ovf_encoding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_overflow |->
      (out_result[RW-2:FRAC_W] == EXP_ONES && out_result[FRAC_W-1:0] == '0) ||
      (out_result[RW-2:FRAC_W] == EXP_ONES - 1'b1 && &out_result[FRAC_W-1:0]));
  assert_no_uf_with_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_underflow && out_overflow));
  assert_flush_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && flush_en && ($signed(in_exp) < EMIN) |=> out_underflow && out_inexact);
  assert_flush_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && flush_en && ($signed(in_exp) < EMIN) |=> out_result[RW-1] == $past(in_sign));
endmodule

// File: tb/tb_fp_round_pack.sv
`timescale 1ns/1ps
module tb_fp_round_pack;
  localparam int SE = 4, SF = 3, SX = 7;
  localparam int SEMIN = -6, SEMAX = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              s_v = 0, s_s = 0, s_fl = 0, s_ue = 0;
  logic [SX-1:0]     s_e = '0;
  logic [SF+3:0]     s_m = '0;
  logic [1:0]        s_rm = '0;
  logic              s_ov_v, s_ix, s_uf, s_ov;
  logic [SE+SF:0]    s_res;

  logic              d_v = 0, d_s = 0, d_fl = 0, d_ue = 0;
  logic [12:0]       d_e = '0;
  logic [55:0]       d_m = '0;
  logic [1:0]        d_rm = '0;
  logic              d_ov_v, d_ix, d_uf, d_ov;
  logic [63:0]       d_res;

  fp_round_pack #(.EXP_W(SE), .FRAC_W(SF), .XE_W(SX)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(s_v), .in_sign(s_s), .in_exp(s_e), .in_mant(s_m),
    .rnd_mode(s_rm), .flush_en(s_fl), .uf_trap_en(s_ue), .out_valid(s_ov_v),
    .out_result(s_res), .out_inexact(s_ix), .out_underflow(s_uf), .out_overflow(s_ov));

  fp_round_pack dut_d (
    .clk(clk), .rst_n(rst_n), .in_valid(d_v), .in_sign(d_s), .in_exp(d_e), .in_mant(d_m),
    .rnd_mode(d_rm), .flush_en(d_fl), .uf_trap_en(d_ue), .out_valid(d_ov_v),
    .out_result(d_res), .out_inexact(d_ix), .out_underflow(d_uf), .out_overflow(d_ov));

  int checks = 0, fails = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit rnd_up(input bit s, input int md, input longint q, input longint r,
                                input longint d);
    case (md)
      0: return (2*r > d) || (2*r == d && q[0]);
      2: return r != 0 && !s;
      3: return r != 0 && s;
      default: return 0;
    endcase
  endfunction

  task automatic model(input bit s, input int xe, input int m, input int md, input bit fl,
                       input bit ue, output logic [7:0] res, output bit ix, output bit uf,
                       output bit ov, output string tag);
    int g, sh; longint q, r, d; bit tiny, ext;
    ext = (md == 2 && !s) || (md == 3 && s);
    ov = 0;
    if (xe < SEMIN && fl) begin
      ix = 1; uf = 1; tag = "R9";
      res = {s, 4'h0, ext ? 3'b001 : 3'b000};
      return;
    end
    g  = (xe < SEMIN) ? SEMIN : xe;
    sh = 3 + g - xe;
    if (sh > 40) begin q = 0; r = 1; d = 64'h4000_0000_0000_0000; end
    else begin d = 64'sd1 << sh; q = m >> sh; r = m % d; end
    ix = r != 0;
    q  = q + rnd_up(s, md, q, r, d);
    if (q == 16) begin q = 8; g++; end
    tiny = xe < SEMIN;
    tag  = tiny ? "R4" : "R2";
    if (xe == SEMIN - 1 && (longint'(m >> 3) + rnd_up(s, md, m >> 3, m & 7, 8)) == 16) begin
      tiny = 0; tag = "R5";
    end
    uf = tiny && ix;
    if (g > SEMAX) begin
      ov = 1; ix = 1; uf = 0; tag = "R8";
      res = (md == 0 || ext) ? {s, 4'hF, 3'b000} : {s, 4'hE, 3'b111};
    end else if (q < 8) begin
      if (ue) uf = 1;
      res = {s, 4'h0, 3'(q)};
    end else begin
      if (!tiny && tag == "R2" && g != xe) tag = "R10";
      res = {s, 4'(g + 7), 3'(q)};
    end
  endtask

  task automatic run_d(input bit s, input int xe, input longint m, input int md, input bit fl,
                       input bit ue, input logic [63:0] er, input bit eix, input bit euf,
                       input bit eov, input string tag);
    d_v = 1; d_s = s; d_e = 13'(xe); d_m = 56'(m); d_rm = 2'(md); d_fl = fl; d_ue = ue;
    @(negedge clk);
    chk({tag, " result"}, d_res, er);
    chk({tag, " flags"}, {d_ix, d_uf, d_ov}, {eix, euf, eov});
    d_v = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] er; bit eix, euf, eov; string tag; logic [7:0] held;
    repeat (3) @(negedge clk);
    chk("R11 valid", s_ov_v, 0);
    chk("R11 result", {s_res, s_ix, s_uf, s_ov}, 0);
    chk("R11 wide", {d_res, d_ov_v}, 0);
    rst_n = 1;
    @(negedge clk);
    for (int fl = 0; fl < 2; fl++)
      for (int ue = 0; ue < 2; ue++)
        for (int md = 0; md < 4; md++)
          for (int s = 0; s < 2; s++)
            for (int xe = -24; xe <= 9; xe++)
              for (int m = 64; m < 128; m++) begin
                s_v = 1; s_s = 1'(s); s_e = SX'(xe); s_m = 7'(m); s_rm = 2'(md);
                s_fl = 1'(fl); s_ue = 1'(ue);
                model(1'(s), xe, m, md, 1'(fl), 1'(ue), er, eix, euf, eov, tag);
                @(negedge clk);
                chk({tag, " result"}, s_res, er);
                chk("R1 valid", s_ov_v, 1);
                chk("R3 inexact", s_ix, eix);
                chk((!eix && euf) ? "R7 underflow" : "R6 underflow", s_uf, euf);
                chk("R8 overflow", s_ov, eov);
              end
    s_e = SX'(-64); s_m = 7'd64; s_s = 0; s_rm = 2; s_fl = 0; s_ue = 0;
    @(negedge clk);
    chk("R4 clamp result", s_res, 8'h01);
    chk("R6 clamp underflow", s_uf, 1);
    held = s_res;
    s_v = 0; s_e = 0; s_m = 7'd127;
    @(negedge clk);
    chk("R1 idle valid", s_ov_v, 0);
    chk("R1 idle hold", s_res, held);
    run_d(0, 0, 64'h80_0000_0000_0000, 0, 0, 0, 64'h3FF0_0000_0000_0000, 0, 0, 0, "R10 one");
    run_d(1, 5, 64'h80_0000_0000_0004, 0, 0, 0, 64'hC040_0000_0000_0000, 1, 0, 0, "R2 tie even");
    run_d(0, 1023, 64'hFF_FFFF_FFFF_FFFC, 0, 0, 0, 64'h7FF0_0000_0000_0000, 1, 0, 1, "R8 carry inf");
    run_d(0, 1024, 64'h80_0000_0000_0000, 1, 0, 0, 64'h7FEF_FFFF_FFFF_FFFF, 1, 0, 1, "R8 max");
    run_d(0, -1030, 64'h80_0000_0000_0000, 2, 1, 0, 64'h0000_0000_0000_0001, 1, 1, 0, "R9 flush");
    run_d(1, -1100, 64'h80_0000_0000_0000, 3, 0, 0, 64'h8000_0000_0000_0001, 1, 1, 0, "R4 deep");
    run_d(0, -1023, 64'h80_0000_0000_0000, 1, 0, 1, 64'h0008_0000_0000_0000, 0, 1, 0, "R7 exact");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule